// File: doc/BRIEF.md
# Serial In-System Programming Target

This block is the target end of a byte-oriented serial programming link. A host drives a serial clock and a data line into the block and reads a return data line back, while an active-low programming-mode input holds the target in programming mode. Every instruction is a frame of exactly four bytes. The first byte of a frame selects the operation. The block samples the serial clock with its own system clock and finds the edges of the serial clock there. It takes in incoming bits on serial-clock rising edges and moves the return line on falling edges.

Frames are refused until an unlock frame with a correct sync byte has been taken in. While that unlock frame is shifted in, the block returns its second byte during the third byte, so the host can confirm that bit alignment is correct. Once unlocked, the block fills a page buffer of 16-bit words one byte at a time, and a low byte must come before the high byte of the same word. A separate frame commits the page under a 7-bit page number. Another frame writes an EEPROM byte, with erase implied, to a downstream strobe. A poll frame reports whether a modelled write timer is still running. A write frame that arrives while the timer runs is dropped.

The control state machine has four states. LOCKED is the state after reset and after a release. OPEN means programming is enabled. COMMIT issues the page-commit pulse for one cycle. EEWR issues the EEPROM strobe for one cycle. The transitions are: LOCKED to OPEN on a good unlock frame; OPEN to COMMIT on an accepted page-write frame; OPEN to EEWR on an accepted EEPROM-write frame; COMMIT to OPEN and EEWR to OPEN after one cycle; any state to LOCKED while the programming-mode input is high.

Top module: `isp_target`

## Requirements
- R1: Bits on `mosi` are taken on rising edges of `sck`, most significant bit first. `miso` changes only after a falling edge of `sck`, and never while `sck` is high.
- R2: While locked, every frame except a good unlock frame has no effect: the buffer, the commit strobe and the EEPROM strobe are unchanged. `miso` reads 0 except for the echo byte of R3.
- R3: During the third byte of any frame whose first byte is 0xAC, `miso` returns the frame's second byte. The block unlocks only when that second byte is 0x53.
- R4: A frame takes effect only after all 32 bits are shifted in, whether or not the echo was correct.
- R5: The frame 0x40, x, idx, d writes d into the low byte of buffer word idx[5:0] and arms that word for a high-byte load.
- R6: The frame 0x48, x, idx, d writes d into the high byte of word idx[5:0] only if that word is armed, and then disarms it. If the word is not armed, the frame changes nothing.
- R7: The frame 0x4C, p, x, x gives one `commit_o` pulse with `commit_page_o` = p[6:0] and starts the flash write timer.
- R8: The frame 0xC0, x, a, d gives one `ee_wr_o` pulse with `ee_addr_o` = a[5:0] and `ee_data_o` = d, and starts the EEPROM write timer.
- R9: In the frame 0xF0, x, x, x, the fourth byte returned on `miso` is 0x01 while a write timer runs and 0x00 otherwise. Every other returned byte is 0x00, except the echo of R3.
- R10: The flash timer runs 600 clock cycles and the EEPROM timer runs 400. A page-write or EEPROM-write frame that completes while either timer runs is dropped.
- R11: While `prog_rst_n` is high, the bit and byte counters are held at zero, `miso` is driven low and the block is locked. When the input falls again, a fresh frame is taken in aligned to its first bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| prog_rst_n | input | 1 | Active-low programming-mode hold; high releases and locks |
| sck | input | 1 | Serial clock from the host |
| mosi | input | 1 | Serial data in |
| miso | output | 1 | Serial data out |
| commit_o | output | 1 | One-cycle page commit pulse |
| commit_page_o | output | 7 | Page number of the commit |
| buf_rd_idx_i | input | 6 | Page buffer read index used by the array writer |
| buf_rd_data_o | output | 16 | Buffer word at the read index, high byte above low byte |
| ee_wr_o | output | 1 | One-cycle EEPROM write strobe |
| ee_addr_o | output | 6 | EEPROM byte address |
| ee_data_o | output | 8 | EEPROM byte data |

## Verification
The bench sends an unlock frame with a wrong sync byte and checks two things: the echo returns the byte that was sent, and later writes are still refused. A design that echoed a constant, or that unlocked anyway, would fail here. It loads high bytes into words that are not armed, and then loads a second high byte after a pair has already completed. A block without the ordering rule would corrupt those words. It issues an EEPROM write while the flash timer is still running and expects that write to be dropped. It also checks that the poll flips from 1 to 0 once the timer has expired. Finally, it releases the programming-mode input in the middle of a byte and checks that the block has re-locked and that the next frame is read aligned.

// File: rtl/isp_pkg.sv
package isp_pkg;
    localparam int FRAME_BYTES = 4;
    localparam int BCNT_W      = $clog2(FRAME_BYTES);
    localparam int HEAD_W      = (FRAME_BYTES - 1) * 8;

    localparam logic [7:0] OP_UNLOCK  = 8'hAC;
    localparam logic [7:0] SYNC_CODE  = 8'h53;
    localparam logic [7:0] OP_LOAD_LO = 8'h40;
    localparam logic [7:0] OP_LOAD_HI = 8'h48;
    localparam logic [7:0] OP_WR_PAGE = 8'h4C;
    localparam logic [7:0] OP_WR_EE   = 8'hC0;
    localparam logic [7:0] OP_POLL    = 8'hF0;

    typedef enum logic [1:0] {
        S_LOCKED = 2'd0,
        S_OPEN   = 2'd1,
        S_COMMIT = 2'd2,
        S_EEWR   = 2'd3
    } isp_state_t;
endpackage

// File: rtl/isp_shifter.sv
module isp_shifter
    import isp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold,
    input  logic              sck,
    input  logic              mosi,
    input  logic [7:0]        tx_byte,
    output logic              miso,
    output logic              byte_end,
    output logic [BCNT_W-1:0] byte_idx,
    output logic [7:0]        rx_byte,
    output logic [HEAD_W-1:0] head,
    output logic              instr_done
);
    logic              sck_q;
    logic              rise, fall;
    logic [2:0]        bit_cnt;
    logic [BCNT_W-1:0] byte_cnt;
    logic [7:0]        rx_sr;
    logic [7:0]        tx_sr;
    logic [7:0]        head_q [FRAME_BYTES-1];

    assign rise       = sck & ~sck_q;
    assign fall       = ~sck & sck_q;
    assign rx_byte    = {rx_sr[6:0], mosi};
    assign byte_end   = rise && !hold && (bit_cnt == 3'd7);
    assign byte_idx   = byte_cnt;
    assign instr_done = byte_end && (byte_cnt == BCNT_W'(FRAME_BYTES - 1));

    for (genvar g = 0; g < FRAME_BYTES - 1; g++) begin : g_head
        assign head[g*8 +: 8] = head_q[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_q    <= 1'b0;
            bit_cnt  <= '0;
            byte_cnt <= '0;
            rx_sr    <= '0;
            tx_sr    <= '0;
            miso     <= 1'b0;
            for (int i = 0; i < FRAME_BYTES - 1; i++) head_q[i] <= '0;
        end else begin
            sck_q <= sck;
            if (hold) begin
                bit_cnt  <= '0;
                byte_cnt <= '0;
                tx_sr    <= '0;
                miso     <= 1'b0;
            end else begin
                if (rise) begin
                    rx_sr <= rx_byte;
                    if (bit_cnt == 3'd7) begin
                        bit_cnt <= '0;
                        tx_sr   <= tx_byte;
                        if (byte_cnt == BCNT_W'(FRAME_BYTES - 1)) begin
                            byte_cnt <= '0;
                        end else begin
                            head_q[byte_cnt] <= rx_byte;
                            byte_cnt         <= byte_cnt + 1'b1;
                        end
                    end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
                if (fall) begin
                    miso  <= tx_sr[7];
                    tx_sr <= {tx_sr[6:0], 1'b0};
                end
            end
        end
    end

    a_r1_miso_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (miso != $past(miso)) |-> ($past(fall) || $past(hold)));

    a_r11_release_clears: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (bit_cnt == 3'd0 && byte_cnt == '0 && !miso));

    a_r4_frame_wraps: assert property (@(posedge clk) disable iff (!rst_n)
        instr_done |=> (byte_cnt == '0 && bit_cnt == 3'd0));
endmodule

// File: rtl/isp_ctrl.sv
module isp_ctrl
    import isp_pkg::*;
#(
    parameter int IDX_W  = 6,
    parameter int PAGE_W = 7,
    parameter int EE_AW  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold,
    input  logic              byte_end,
    input  logic [BCNT_W-1:0] byte_idx,
    input  logic [7:0]        rx_byte,
    input  logic [HEAD_W-1:0] head,
    input  logic              instr_done,
    input  logic              busy,
    output logic [7:0]        tx_byte,
    output logic              lo_we,
    output logic              hi_we,
    output logic [IDX_W-1:0]  ld_idx,
    output logic [7:0]        ld_data,
    output logic              commit_o,
    output logic [PAGE_W-1:0] commit_page,
    output logic              ee_wr,
    output logic [EE_AW-1:0]  ee_addr,
    output logic [7:0]        ee_data,
    output logic              start_flash,
    output logic              start_ee
);
    isp_state_t        state, state_nx;
    logic [7:0]        op, arg1, arg2;
    logic              open_done, take_page, take_ee;
    logic [PAGE_W-1:0] page_q;
    logic [EE_AW-1:0]  ee_addr_q;
    logic [7:0]        ee_data_q;

    assign op        = head[7:0];
    assign arg1      = head[15:8];
    assign arg2      = head[23:16];
    assign open_done = (state == S_OPEN) && instr_done;
    assign take_page = open_done && (op == OP_WR_PAGE) && !busy;
    assign take_ee   = open_done && (op == OP_WR_EE) && !busy;

    always_comb begin
        tx_byte = 8'h00;
        if (byte_end && byte_idx == BCNT_W'(1) && op == OP_UNLOCK)
            tx_byte = rx_byte;
        else if (byte_end && byte_idx == BCNT_W'(2) && op == OP_POLL && state != S_LOCKED)
            tx_byte = {7'b0, busy};
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_LOCKED: if (instr_done && op == OP_UNLOCK && arg1 == SYNC_CODE) state_nx = S_OPEN;
            S_OPEN: begin
                if (take_page)    state_nx = S_COMMIT;
                else if (take_ee) state_nx = S_EEWR;
            end
            S_COMMIT: state_nx = S_OPEN;
            S_EEWR:   state_nx = S_OPEN;
            default:  state_nx = S_LOCKED;
        endcase
        if (hold) state_nx = S_LOCKED;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_LOCKED;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            page_q    <= '0;
            ee_addr_q <= '0;
            ee_data_q <= '0;
        end else begin
            if (take_page) page_q <= arg1[PAGE_W-1:0];
            if (take_ee) begin
                ee_addr_q <= arg2[EE_AW-1:0];
                ee_data_q <= rx_byte;
            end
        end
    end

    always_comb begin
        lo_we       = open_done && (op == OP_LOAD_LO);
        hi_we       = open_done && (op == OP_LOAD_HI);
        ld_idx      = arg2[IDX_W-1:0];
        ld_data     = rx_byte;
        commit_o    = (state == S_COMMIT);
        start_flash = (state == S_COMMIT);
        ee_wr       = (state == S_EEWR);
        start_ee    = (state == S_EEWR);
        commit_page = page_q;
        ee_addr     = ee_addr_q;
        ee_data     = ee_data_q;
    end

    a_r7_commit_after_frame: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |-> ($past(state) == S_OPEN && $past(instr_done) && !$past(busy)));

    a_r8_ee_after_frame: assert property (@(posedge clk) disable iff (!rst_n)
        ee_wr |-> ($past(state) == S_OPEN && $past(instr_done) && !$past(busy)));

    a_r2_locked_no_loads: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_we || hi_we) |=> (state != S_LOCKED || $past(hold)));
endmodule

// File: rtl/isp_page_buf.sv
module isp_page_buf #(
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lo_we,
    input  logic             hi_we,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [7:0]       wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [15:0]      rd_data
);
    localparam int WORDS = 1 << IDX_W;

    logic [7:0]       lo_mem [WORDS];
    logic [7:0]       hi_mem [WORDS];
    logic [WORDS-1:0] armed;
    logic             hi_ok;

    assign hi_ok   = hi_we && armed[wr_idx];
    assign rd_data = {hi_mem[rd_idx], lo_mem[rd_idx]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed <= '0;
            for (int i = 0; i < WORDS; i++) begin
                lo_mem[i] <= '0;
                hi_mem[i] <= '0;
            end
        end else if (lo_we) begin
            lo_mem[wr_idx] <= wr_data;
            armed[wr_idx]  <= 1'b1;
        end else if (hi_ok) begin
            hi_mem[wr_idx] <= wr_data;
            armed[wr_idx]  <= 1'b0;
        end
    end

    a_r6_high_only_when_armed: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_we && !lo_we) |=> ($past(armed[wr_idx]) ? !armed[$past(wr_idx)]
                                                    : (hi_mem[$past(wr_idx)] == $past(hi_mem[wr_idx]))));

    a_r5_low_arms: assert property (@(posedge clk) disable iff (!rst_n)
        lo_we |=> armed[$past(wr_idx)]);
endmodule

// File: rtl/isp_busy_timer.sv
module isp_busy_timer #(
    parameter int FLASH_WAIT = 600,
    parameter int EE_WAIT    = 400
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_flash,
    input  logic start_ee,
    output logic busy
);
    localparam int MAXW  = (FLASH_WAIT > EE_WAIT) ? FLASH_WAIT : EE_WAIT;
    localparam int CNT_W = $clog2(MAXW + 1);

    logic [CNT_W-1:0] cnt;

    assign busy = (cnt != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           cnt <= '0;
        else if (start_flash) cnt <= CNT_W'(FLASH_WAIT);
        else if (start_ee)    cnt <= CNT_W'(EE_WAIT);
        else if (busy)        cnt <= cnt - 1'b1;
    end

    a_r10_no_start_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (start_flash || start_ee) |-> !busy);

    a_r10_counts_down: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(busy) && !$past(start_flash) && !$past(start_ee)) |-> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/isp_target.sv
module isp_target
    import isp_pkg::*;
#(
    parameter int IDX_W      = 6,
    parameter int PAGE_W     = 7,
    parameter int EE_AW      = 6,
    parameter int FLASH_WAIT = 600,
    parameter int EE_WAIT    = 400
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_rst_n,
    input  logic              sck,
    input  logic              mosi,
    output logic              miso,
    output logic              commit_o,
    output logic [PAGE_W-1:0] commit_page_o,
    input  logic [IDX_W-1:0]  buf_rd_idx_i,
    output logic [15:0]       buf_rd_data_o,
    output logic              ee_wr_o,
    output logic [EE_AW-1:0]  ee_addr_o,
    output logic [7:0]        ee_data_o
);
    logic              hold;
    logic              byte_end, instr_done, busy;
    logic [BCNT_W-1:0] byte_idx;
    logic [7:0]        rx_byte, tx_byte, ld_data;
    logic [HEAD_W-1:0] head;
    logic              lo_we, hi_we, start_flash, start_ee;
    logic [IDX_W-1:0]  ld_idx;

    assign hold = prog_rst_n;

    isp_shifter u_shift (
        .clk(clk), .rst_n(rst_n), .hold(hold), .sck(sck), .mosi(mosi),
        .tx_byte(tx_byte), .miso(miso), .byte_end(byte_end), .byte_idx(byte_idx),
        .rx_byte(rx_byte), .head(head), .instr_done(instr_done)
    );

    isp_ctrl #(.IDX_W(IDX_W), .PAGE_W(PAGE_W), .EE_AW(EE_AW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .hold(hold), .byte_end(byte_end),
        .byte_idx(byte_idx), .rx_byte(rx_byte), .head(head), .instr_done(instr_done),
        .busy(busy), .tx_byte(tx_byte), .lo_we(lo_we), .hi_we(hi_we),
        .ld_idx(ld_idx), .ld_data(ld_data), .commit_o(commit_o),
        .commit_page(commit_page_o), .ee_wr(ee_wr_o), .ee_addr(ee_addr_o),
        .ee_data(ee_data_o), .start_flash(start_flash), .start_ee(start_ee)
    );

    isp_page_buf #(.IDX_W(IDX_W)) u_buf (
        .clk(clk), .rst_n(rst_n), .lo_we(lo_we), .hi_we(hi_we),
        .wr_idx(ld_idx), .wr_data(ld_data), .rd_idx(buf_rd_idx_i),
        .rd_data(buf_rd_data_o)
    );

    isp_busy_timer #(.FLASH_WAIT(FLASH_WAIT), .EE_WAIT(EE_WAIT)) u_timer (
        .clk(clk), .rst_n(rst_n), .start_flash(start_flash),
        .start_ee(start_ee), .busy(busy)
    );
endmodule

// File: tb/test_isp_target.sv
module test_isp_target;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        prog_rst_n = 1'b0;
    logic        sck = 1'b0;
    logic        mosi = 1'b0;
    logic        miso;
    logic        commit_o;
    logic [6:0]  commit_page_o;
    logic [5:0]  buf_rd_idx_i = '0;
    logic [15:0] buf_rd_data_o;
    logic        ee_wr_o;
    logic [5:0]  ee_addr_o;
    logic [7:0]  ee_data_o;

    int compared = 0;
    int mismatched = 0;
    int r1_bad = 0;
    int commit_cnt = 0;
    int ee_cnt = 0;
    logic [6:0] last_page = '0;
    logic [5:0] last_ee_addr = '0;
    logic [7:0] last_ee_data = '0;
    bit done = 1'b0;

    logic [7:0] m_lo [64];
    logic [7:0] m_hi [64];
    bit         m_arm [64];

    always #(CLK_PERIOD / 2) clk = ~clk;

    isp_target i_isp_target (
        .clk(clk), .rst_n(rst_n), .prog_rst_n(prog_rst_n), .sck(sck), .mosi(mosi),
        .miso(miso), .commit_o(commit_o), .commit_page_o(commit_page_o),
        .buf_rd_idx_i(buf_rd_idx_i), .buf_rd_data_o(buf_rd_data_o),
        .ee_wr_o(ee_wr_o), .ee_addr_o(ee_addr_o), .ee_data_o(ee_data_o)
    );

    always @(posedge clk) begin
        if (commit_o) begin commit_cnt++; last_page <= commit_page_o; end
        if (ee_wr_o) begin ee_cnt++; last_ee_addr <= ee_addr_o; last_ee_data <= ee_data_o; end
    end

    function automatic logic [15:0] exp_word(input int idx);
        return {m_hi[idx], m_lo[idx]};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic send_byte(input logic [7:0] tx, output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) begin
            mosi = tx[i];
            repeat (4) @(negedge clk);
            rx[i] = miso;
            sck = 1'b1;
            repeat (4) @(negedge clk);
            if (miso !== rx[i]) r1_bad++;
            sck = 1'b0;
        end
    endtask

    task automatic xfer(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c,
                        input logic [7:0] d, output logic [31:0] r);
        logic [7:0] r0, r1, r2, r3;
        send_byte(a, r0);
        send_byte(b, r1);
        send_byte(c, r2);
        send_byte(d, r3);
        r = {r0, r1, r2, r3};
        repeat (8) @(negedge clk);
    endtask

    task automatic read_word(input int idx, output logic [15:0] w);
        buf_rd_idx_i = 6'(idx);
        @(negedge clk);
        w = buf_rd_data_o;
    endtask

    task automatic m_load_lo(input int idx, input logic [7:0] d);
        logic [31:0] r;
        xfer(8'h40, 8'h00, 8'(idx), d, r);
        m_lo[idx] = d;
        m_arm[idx] = 1'b1;
    endtask

    task automatic m_load_hi(input int idx, input logic [7:0] d);
        logic [31:0] r;
        xfer(8'h48, 8'h00, 8'(idx), d, r);
        if (m_arm[idx]) begin m_hi[idx] = d; m_arm[idx] = 1'b0; end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            mismatched++;
            compared++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        logic [15:0] w;
        logic [7:0]  tmp;
        int c0;
        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < 64; i++) begin m_lo[i] = '0; m_hi[i] = '0; m_arm[i] = 1'b0; end
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // Reset state
        chk("reset miso", 32'(miso), 0);
        read_word(0, w);
        chk("reset buffer", 32'(w), 0);

        // R2: locked, loads and writes ignored, miso low
        xfer(8'h40, 8'h00, 8'h03, 8'hA5, r);
        chk("R2 locked miso", r, 0);
        read_word(3, w);
        chk("R2 locked load ignored", 32'(w), 0);

        // R3: wrong sync byte echoed, still locked
        xfer(8'hAC, 8'h52, 8'h00, 8'h00, r);
        chk("R3 wrong echo", r, 32'h0000_5200);
        xfer(8'h4C, 8'h11, 8'h00, 8'h00, r);
        chk("R3 no unlock on bad sync", 32'(commit_cnt), 0);

        // R3, R9: good unlock
        xfer(8'hAC, 8'h53, 8'h00, 8'h00, r);
        chk("R3 sync echo", r, 32'h0000_5300);

        // R7: page commit
        xfer(8'h4C, 8'h55, 8'h00, 8'h00, r);
        chk("R7 commit count", 32'(commit_cnt), 1);
        chk("R7 commit page", 32'(last_page), 32'h55);
        // R9: poll while busy
        xfer(8'hF0, 8'h00, 8'h00, 8'h00, r);
        chk("R9 poll busy", r, 32'h0000_0001);
        // R10: EEPROM write while busy dropped
        xfer(8'hC0, 8'h00, 8'h07, 8'h99, r);
        chk("R10 write dropped while busy", 32'(ee_cnt), 0);
        repeat (1000) @(negedge clk);
        xfer(8'hF0, 8'h00, 8'h00, 8'h00, r);
        chk("R9 poll ready", r, 0);

        // R6: high load without armed low ignored
        m_load_hi(5, 8'h77);
        read_word(5, w);
        chk("R6 high without low", 32'(w), 32'(exp_word(5)));
        // R5 then R6: pair, then second high ignored
        m_load_lo(5, 8'h12);
        read_word(5, w);
        chk("R5 low load", 32'(w), 32'(exp_word(5)));
        m_load_hi(5, 8'h34);
        read_word(5, w);
        chk("R6 high after low", 32'(w), 32'h3412);
        m_load_hi(5, 8'hEE);
        read_word(5, w);
        chk("R6 second high ignored", 32'(w), 32'h3412);

        // R5/R6 constrained random loads against model
        for (int n = 0; n < 40; n++) begin
            int idx, kind;
            idx = int'($urandom % 64);
            kind = int'($urandom % 3);
            if (kind == 0) m_load_lo(idx, 8'($urandom));
            else if (kind == 1) m_load_hi(idx, 8'($urandom));
            else begin m_load_lo(idx, 8'($urandom)); m_load_hi(idx, 8'($urandom)); end
            read_word(idx, w);
            chk("R5 R6 random word", 32'(w), 32'(exp_word(idx)));
        end

        // R8: EEPROM write
        xfer(8'hC0, 8'h00, 8'h2A, 8'h6C, r);
        chk("R8 ee count", 32'(ee_cnt), 1);
        chk("R8 ee addr", 32'(last_ee_addr), 32'h2A);
        chk("R8 ee data", 32'(last_ee_data), 32'h6C);
        xfer(8'hF0, 8'h00, 8'h00, 8'h00, r);
        chk("R9 poll ee busy", r, 32'h0000_0001);
        repeat (1000) @(negedge clk);

        // R4: effect only after fourth byte
        c0 = commit_cnt;
        send_byte(8'h4C, tmp);
        send_byte(8'h21, tmp);
        send_byte(8'h00, tmp);
        repeat (8) @(negedge clk);
        chk("R4 no effect after three bytes", 32'(commit_cnt), 32'(c0));
        send_byte(8'h00, tmp);
        repeat (8) @(negedge clk);
        chk("R4 effect after fourth byte", 32'(commit_cnt), 32'(c0 + 1));
        chk("R4 page", 32'(last_page), 32'h21);
        repeat (1000) @(negedge clk);

        // R11: release mid-byte, re-locks and realigns
        mosi = 1'b1;
        for (int i = 0; i < 3; i++) begin
            repeat (4) @(negedge clk); sck = 1'b1;
            repeat (4) @(negedge clk); sck = 1'b0;
        end
        prog_rst_n = 1'b1;
        repeat (6) @(negedge clk);
        chk("R11 miso low on release", 32'(miso), 0);
        prog_rst_n = 1'b0;
        repeat (4) @(negedge clk);
        c0 = commit_cnt;
        xfer(8'h4C, 8'h0F, 8'h00, 8'h00, r);
        chk("R11 locked after release", 32'(commit_cnt), 32'(c0));
        xfer(8'hAC, 8'h53, 8'h00, 8'h00, r);
        chk("R11 realigned echo", r, 32'h0000_5300);
        xfer(8'h4C, 8'h0F, 8'h00, 8'h00, r);
        chk("R11 commit after re-unlock", 32'(commit_cnt), 32'(c0 + 1));

        chk("R1 miso stable while sck high", 32'(r1_bad), 0);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule